// File: doc/BRIEF.md
# OLED Controller Command Decoder and RAM Pointer

This block sits behind the host bus of a small monochrome OLED controller. It takes a stream of tagged bytes from the host: command bytes, display-data writes, display-data reads and status reads. From that stream it keeps the controller's configuration registers and the page/column pointer into a page-organised display RAM of 132 columns by 8 pages of bytes. Most commands take one byte. Five commands take a second byte as their parameter. Display-data writes go straight to the RAM port, and the column advances after each one.

Reads go through a one-deep latch. A data read returns whatever the latch held and then refills the latch from the RAM location under the pointer. After setting an address, the host therefore issues one dummy read before the first real one. A read-modify-write mode saves the column and stops reads from moving it, so the host can read a byte, modify it and write it back in place. Leaving the mode puts back the column that was saved.

The input is a valid/ready stream. `in_ready` is low while a read or status response waits in the output register. `rsp_valid` stays high, and `rsp_data` stays unchanged, until `rsp_ready` is seen high at a clock edge. The RAM port has no back-pressure. A read issued on `ram_re` must return `ram_rdata` in the following cycle.

Top module: `oled_cmd_ptr`

## Requirements
- R1: After reset the registers hold these values: contrast 80h, column 0, page 0, start line 0, display off, remap/flip/entire/inverse all 0, divide ratio 1, oscillator field 5, pre-charge 22h, DC-DC byte 8Bh, common-pad byte 12h, and no response pending.
- R2: `in_kind` encodes the byte type: 0 command, 1 display-data write, 2 display-data read, 3 status read. The command bytes that move the pointer work as follows:
  - 00h–0Fh replace the low nibble of the column.
  - 10h–1Fh replace the high nibble of the column.
  - B0h–B7h load the page from bits 2..0.
  - 40h–7Fh load the start line from bits 5..0.
- R3: These command bytes set single flags:
  - A0h/A1h set segment remap from bit 0.
  - A4h/A5h set entire-display-on from bit 0.
  - A6h/A7h set inverse from bit 0.
  - AEh/AFh set display-on from bit 0.
  - C0h/C8h set the common scan flip from bit 3.
  - E3h changes nothing.
- R4: The bytes 81h (contrast), D5h (clock divide/oscillator), D9h (pre-charge), ADh (DC-DC) and DAh (common-pad) each arm a parameter wait. The next command byte is stored whole into that register and is not decoded. `div_ratio` equals the stored low nibble plus 1, and `osc_freq` equals its high nibble.
- R5: A display-data byte that arrives during a parameter wait causes no RAM write and does not move the column. The wait stays armed until a command byte arrives.
- R6: An accepted display-data write drives `ram_we` in the same cycle, with the current page, column and byte. The column then advances by one. No write or read ever changes the page.
- R7: The column stops advancing once it reaches 131 (or any higher value loaded by command).
- R8: An accepted data read pulses `ram_re` at the current pointer. The next cycle presents a response carrying the latch contents from before that read, and the latch then loads the RAM byte. Outside read-modify-write mode the column advances by one.
- R9: E0h saves the column and enters read-modify-write mode. In that mode reads leave the column unchanged and writes still advance it. EEh restores the saved column and leaves the mode.
- R10: A status read responds with bit 7 = 0 (never busy), bit 6 = inverse of display-on, and bits 5..0 = 0.
- R11: While `rsp_valid` is high, `in_ready` is low and no RAM access occurs. A response not taken holds its data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_kind | input | 2 | Byte type: 0 cmd, 1 data write, 2 data read, 3 status read |
| in_byte | input | 8 | Command or data byte |
| rsp_valid | output | 1 | Read/status response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8 | Response byte |
| ram_we | output | 1 | RAM write strobe |
| ram_re | output | 1 | RAM read strobe, data due next cycle |
| ram_page | output | PAGE_W | Current page pointer |
| ram_col | output | COL_W | Current column pointer |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after ram_re |
| contrast | output | 8 | Contrast register |
| start_line | output | LINE_W | Display start line |
| seg_remap | output | 1 | Segment remap flag |
| com_flip | output | 1 | Common scan reverse flag |
| entire_on | output | 1 | Entire-display-on flag |
| inverse_on | output | 1 | Inverse display flag |
| disp_on | output | 1 | Display on flag |
| div_ratio | output | 5 | Clock divide ratio, 1 to 16 |
| osc_freq | output | 4 | Oscillator frequency field |
| precharge | output | 8 | Pre-charge register |
| dcdc_cfg | output | 8 | DC-DC register |
| compad_cfg | output | 8 | Common-pad configuration register |

## Verification
Two pairs of events can fall into one cycle.

The first pair is the latch refill from the previous read and a response that back-pressure is holding. The bench keeps `rsp_ready` low for a cycle after each read, then checks that the held byte is still the old latch value and that the following read returns the refilled byte.

The second pair is an armed parameter wait and an arriving display-data byte. The bench sends data writes between a two-byte opcode and its parameter. It then judges at the ports that `ram_we` stayed low, that the column stayed put, and that the next command byte landed in the parameter register.

// File: rtl/oled_cmd_pkg.sv
package oled_cmd_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    K_CMD    = 2'd0,
    K_DATA   = 2'd1,
    K_RDDATA = 2'd2,
    K_RDSTAT = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    P_NONE     = 3'd0,
    P_CONTRAST = 3'd1,
    P_CLKDIV   = 3'd2,
    P_PRECHG   = 3'd3,
    P_DCDC     = 3'd4,
    P_COMCFG   = 3'd5
  } pend_e;

  typedef struct packed {
    logic  set_col_lo;
    logic  set_col_hi;
    logic  set_start;
    logic  set_page;
    logic  set_remap;
    logic  set_entire;
    logic  set_inverse;
    logic  set_disp;
    logic  set_scan;
    logic  rmw_enter;
    logic  rmw_exit;
    pend_e arm;
  } dec_s;

  localparam logic [BYTE_W-1:0] CONTRAST_RST = 8'h80;
  localparam logic [BYTE_W-1:0] CLKDIV_RST   = 8'h50;
  localparam logic [BYTE_W-1:0] PRECHG_RST   = 8'h22;
  localparam logic [BYTE_W-1:0] DCDC_RST     = 8'h8B;
  localparam logic [BYTE_W-1:0] COMCFG_RST   = 8'h12;
endpackage

// File: rtl/ocp_decode.sv
module ocp_decode
  import oled_cmd_pkg::*;
(
  input  logic [BYTE_W-1:0] cmd,
  output dec_s              dec
);
  always_comb begin
    dec     = '0;
    dec.arm = P_NONE;
    casez (cmd)
      8'b0000_????: dec.set_col_lo  = 1'b1;
      8'b0001_????: dec.set_col_hi  = 1'b1;
      8'b01??_????: dec.set_start   = 1'b1;
      8'b1011_0???: dec.set_page    = 1'b1;
      8'b1010_000?: dec.set_remap   = 1'b1;
      8'b1010_010?: dec.set_entire  = 1'b1;
      8'b1010_011?: dec.set_inverse = 1'b1;
      8'b1010_111?: dec.set_disp    = 1'b1;
      8'b1100_?000: dec.set_scan    = 1'b1;
      8'hE0:        dec.rmw_enter   = 1'b1;
      8'hEE:        dec.rmw_exit    = 1'b1;
      8'h81:        dec.arm         = P_CONTRAST;
      8'hD5:        dec.arm         = P_CLKDIV;
      8'hD9:        dec.arm         = P_PRECHG;
      8'hAD:        dec.arm         = P_DCDC;
      8'hDA:        dec.arm         = P_COMCFG;
      default:      ;
    endcase
  end
endmodule

// File: rtl/ocp_pointer.sv
module ocp_pointer #(
  parameter int COL_W    = 8,
  parameter int PAGE_W   = 3,
  parameter int LAST_COL = 131
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [3:0]        nib,
  input  logic              ld_page,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              adv,
  input  logic              rmw_enter,
  input  logic              rmw_exit,
  output logic [COL_W-1:0]  col,
  output logic [PAGE_W-1:0] page,
  output logic              rmw_on
);
  localparam int HI_W = COL_W - 4;
  localparam logic [COL_W-1:0] LAST = COL_W'(LAST_COL);

  logic [COL_W-1:0] saved;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col    <= '0;
      page   <= '0;
      saved  <= '0;
      rmw_on <= 1'b0;
    end else begin
      if (ld_lo)
        col[3:0] <= nib;
      else if (ld_hi)
        col[COL_W-1:4] <= nib[HI_W-1:0];
      else if (rmw_exit && rmw_on)
        col <= saved;
      else if (adv && (col < LAST))
        col <= col + 1'b1;

      if (ld_page)
        page <= page_in;

      if (rmw_enter) begin
        rmw_on <= 1'b1;
        saved  <= col;
      end else if (rmw_exit) begin
        rmw_on <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ocp_readpipe.sv
module ocp_readpipe
  import oled_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_rd,
  input  logic              take_stat,
  input  logic [BYTE_W-1:0] stat_byte,
  input  logic [BYTE_W-1:0] ram_rdata,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data
);
  logic              fill;
  logic [BYTE_W-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill      <= 1'b0;
      latch_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      fill <= take_rd;
      if (fill)
        latch_q <= ram_rdata;
      if (take_rd) begin
        rsp_valid <= 1'b1;
        rsp_data  <= latch_q;
      end else if (take_stat) begin
        rsp_valid <= 1'b1;
        rsp_data  <= stat_byte;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/oled_cmd_ptr.sv
module oled_cmd_ptr
  import oled_cmd_pkg::*;
#(
  parameter int COL_W    = 8,
  parameter int PAGE_W   = 3,
  parameter int LINE_W   = 6,
  parameter int LAST_COL = 131
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              ram_we,
  output logic              ram_re,
  output logic [PAGE_W-1:0] ram_page,
  output logic [COL_W-1:0]  ram_col,
  output logic [BYTE_W-1:0] ram_wdata,
  input  logic [BYTE_W-1:0] ram_rdata,
  output logic [BYTE_W-1:0] contrast,
  output logic [LINE_W-1:0] start_line,
  output logic              seg_remap,
  output logic              com_flip,
  output logic              entire_on,
  output logic              inverse_on,
  output logic              disp_on,
  output logic [4:0]        div_ratio,
  output logic [3:0]        osc_freq,
  output logic [BYTE_W-1:0] precharge,
  output logic [BYTE_W-1:0] dcdc_cfg,
  output logic [BYTE_W-1:0] compad_cfg
);
  kind_e             kind;
  pend_e             pend;
  dec_s              dec;
  logic              acc, cmd_acc, dec_en, par_en;
  logic              wr_en, rd_en, st_en, adv, rmw_on;
  logic [BYTE_W-1:0] clkdiv_q, stat_byte;
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] page;

  assign kind     = kind_e'(in_kind);
  assign in_ready = !rsp_valid;
  assign acc      = in_valid && in_ready;
  assign cmd_acc  = acc && (kind == K_CMD);
  assign dec_en   = cmd_acc && (pend == P_NONE);
  assign par_en   = cmd_acc && (pend != P_NONE);
  assign wr_en    = acc && (kind == K_DATA) && (pend == P_NONE);
  assign rd_en    = acc && (kind == K_RDDATA);
  assign st_en    = acc && (kind == K_RDSTAT);
  assign adv      = wr_en || (rd_en && !rmw_on);

  ocp_decode u_decode (
    .cmd (in_byte),
    .dec (dec)
  );

  ocp_pointer #(
    .COL_W    (COL_W),
    .PAGE_W   (PAGE_W),
    .LAST_COL (LAST_COL)
  ) u_pointer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_lo     (dec_en && dec.set_col_lo),
    .ld_hi     (dec_en && dec.set_col_hi),
    .nib       (in_byte[3:0]),
    .ld_page   (dec_en && dec.set_page),
    .page_in   (in_byte[PAGE_W-1:0]),
    .adv       (adv),
    .rmw_enter (dec_en && dec.rmw_enter),
    .rmw_exit  (dec_en && dec.rmw_exit),
    .col       (col),
    .page      (page),
    .rmw_on    (rmw_on)
  );

  assign stat_byte = {1'b0, !disp_on, 6'b0};

  ocp_readpipe u_readpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_rd   (rd_en),
    .take_stat (st_en),
    .stat_byte (stat_byte),
    .ram_rdata (ram_rdata),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign ram_we    = wr_en;
  assign ram_re    = rd_en;
  assign ram_wdata = in_byte;
  assign ram_page  = page;
  assign ram_col   = col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend       <= P_NONE;
      contrast   <= CONTRAST_RST;
      clkdiv_q   <= CLKDIV_RST;
      precharge  <= PRECHG_RST;
      dcdc_cfg   <= DCDC_RST;
      compad_cfg <= COMCFG_RST;
      start_line <= '0;
      seg_remap  <= 1'b0;
      com_flip   <= 1'b0;
      entire_on  <= 1'b0;
      inverse_on <= 1'b0;
      disp_on    <= 1'b0;
    end else if (par_en) begin
      case (pend)
        P_CONTRAST: contrast   <= in_byte;
        P_CLKDIV:   clkdiv_q   <= in_byte;
        P_PRECHG:   precharge  <= in_byte;
        P_DCDC:     dcdc_cfg   <= in_byte;
        P_COMCFG:   compad_cfg <= in_byte;
        default:    ;
      endcase
      pend <= P_NONE;
    end else if (dec_en) begin
      pend <= dec.arm;
      if (dec.set_start)   start_line <= in_byte[LINE_W-1:0];
      if (dec.set_remap)   seg_remap  <= in_byte[0];
      if (dec.set_entire)  entire_on  <= in_byte[0];
      if (dec.set_inverse) inverse_on <= in_byte[0];
      if (dec.set_disp)    disp_on    <= in_byte[0];
      if (dec.set_scan)    com_flip   <= in_byte[3];
    end
  end

  assign div_ratio = {1'b0, clkdiv_q[3:0]} + 5'd1;
  assign osc_freq  = clkdiv_q[7:4];
endmodule

// File: rtl/ocp_checker.sv
module ocp_checker #(
  parameter int COL_W    = 8,
  parameter int PAGE_W   = 3,
  parameter int LAST_COL = 131
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [7:0]        rsp_data,
  input logic              ram_we,
  input logic              ram_re,
  input logic [PAGE_W-1:0] ram_page,
  input logic [COL_W-1:0]  ram_col
);
  localparam logic [COL_W-1:0] LAST = COL_W'(LAST_COL);

  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> ram_col == (($past(ram_col) >= LAST) ? $past(ram_col) : $past(ram_col) + 1'b1)); // R7

  AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_re) |=> $stable(ram_page)); // R6

  AST_READ_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_re |=> rsp_valid); // R8

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11

  AST_STALL_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!ram_we && !ram_re)); // R11
endmodule

bind oled_cmd_ptr ocp_checker #(
  .COL_W    (COL_W),
  .PAGE_W   (PAGE_W),
  .LAST_COL (LAST_COL)
) u_ocp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .ram_we    (ram_we),
  .ram_re    (ram_re),
  .ram_page  (ram_page),
  .ram_col   (ram_col)
);

// File: tb/oled_cmd_ptr_bench.sv
module oled_cmd_ptr_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic [7:0] in_byte = 8'h00;
  logic       rsp_ready = 1'b0;
  logic       in_ready, rsp_valid, ram_we, ram_re;
  logic [7:0] rsp_data, ram_wdata, contrast, precharge, dcdc_cfg, compad_cfg;
  logic [7:0] ram_rdata;
  logic [2:0] ram_page;
  logic [7:0] ram_col;
  logic [5:0] start_line;
  logic       seg_remap, com_flip, entire_on, inverse_on, disp_on;
  logic [4:0] div_ratio;
  logic [3:0] osc_freq;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  oled_cmd_ptr u_oled_cmd_ptr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_byte(in_byte), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .ram_we(ram_we),
    .ram_re(ram_re), .ram_page(ram_page), .ram_col(ram_col),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .contrast(contrast),
    .start_line(start_line), .seg_remap(seg_remap), .com_flip(com_flip),
    .entire_on(entire_on), .inverse_on(inverse_on), .disp_on(disp_on),
    .div_ratio(div_ratio), .osc_freq(osc_freq), .precharge(precharge),
    .dcdc_cfg(dcdc_cfg), .compad_cfg(compad_cfg)
  );

  // RAM with one-cycle read latency
  logic [7:0] bram [2048];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) bram[i] <= 8'h00;
      ram_rdata <= 8'h00;
    end else begin
      if (ram_we) bram[{ram_page, ram_col}] <= ram_wdata;
      if (ram_re) ram_rdata <= bram[{ram_page, ram_col}];
    end
  end

  // reference model state
  int         m_col = 0, m_page = 0, m_saved = 0, m_pend = 0;
  bit         m_rmw = 0;
  logic [5:0] m_start = 0;
  logic [7:0] m_contrast = 8'h80, m_clk = 8'h50, m_pre = 8'h22, m_dcdc = 8'h8B, m_com = 8'h12;
  bit         m_remap = 0, m_entire = 0, m_inv = 0, m_disp = 0, m_scan = 0;
  logic [7:0] m_latch = 8'h00;
  logic [7:0] m_mem [2048];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_idx();
    return m_page * 256 + m_col;
  endfunction

  task automatic m_advance();
    if (m_col < 131) m_col++;
  endtask

  task automatic m_command(input logic [7:0] b);
    if (m_pend != 0) begin
      case (m_pend)
        1: m_contrast = b;
        2: m_clk = b;
        3: m_pre = b;
        4: m_dcdc = b;
        default: m_com = b;
      endcase
      m_pend = 0;
    end else begin
      casez (b)
        8'b0000_????: m_col = (m_col & 8'hF0) | int'(b[3:0]);
        8'b0001_????: m_col = (m_col & 8'h0F) | (int'(b[3:0]) << 4);
        8'b01??_????: m_start = b[5:0];
        8'b1011_0???: m_page = int'(b[2:0]);
        8'b1010_000?: m_remap = b[0];
        8'b1010_010?: m_entire = b[0];
        8'b1010_011?: m_inv = b[0];
        8'b1010_111?: m_disp = b[0];
        8'b1100_?000: m_scan = b[3];
        8'hE0: begin m_rmw = 1; m_saved = m_col; end
        8'hEE: begin if (m_rmw) m_col = m_saved; m_rmw = 0; end
        8'h81: m_pend = 1;
        8'hD5: m_pend = 2;
        8'hD9: m_pend = 3;
        8'hAD: m_pend = 4;
        8'hDA: m_pend = 5;
        default: ;
      endcase
    end
  endtask

  task automatic check_cfg();
    chk("R2 column", ram_col, m_col);
    chk("R2 page", ram_page, m_page);
    chk("R2 start line", start_line, m_start);
    chk("R3 flags", {seg_remap, com_flip, entire_on, inverse_on, disp_on},
        {m_remap, m_scan, m_entire, m_inv, m_disp});
    chk("R4 contrast", contrast, m_contrast);
    chk("R4 div ratio", div_ratio, {1'b0, m_clk[3:0]} + 5'd1);
    chk("R4 osc field", osc_freq, m_clk[7:4]);
    chk("R4 params", {precharge, dcdc_cfg, compad_cfg}, {m_pre, m_dcdc, m_com});
  endtask

  // one transaction; reads also consume the response with one stall cycle
  task automatic send(input logic [1:0] k, input logic [7:0] b);
    logic [7:0] exp_rsp;
    @(negedge clk);
    chk("R11 ready idle", in_ready, 1'b1);
    in_valid = 1'b1; in_kind = k; in_byte = b;
    #1;
    if (k == 2'd1) begin
      chk("R5/R6 write strobe", ram_we, (m_pend == 0));
      if (m_pend == 0) chk("R6 write addr", {ram_page, ram_col, ram_wdata},
                           {3'(m_page), 8'(m_col), b});
    end
    if (k == 2'd2) chk("R8 read strobe", {ram_re, ram_page, ram_col}, {1'b1, 3'(m_page), 8'(m_col)});
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    exp_rsp = 8'h00;
    case (k)
      2'd0: m_command(b);
      2'd1: if (m_pend == 0) begin m_mem[m_idx()] = b; m_advance(); end
      2'd2: begin
        exp_rsp = m_latch;
        m_latch = m_mem[m_idx()];
        if (!m_rmw) m_advance();
      end
      default: exp_rsp = {1'b0, ~m_disp, 6'b0};
    endcase
    if (k >= 2'd2) begin
      @(negedge clk);
      chk(k == 2'd2 ? "R8 read data" : "R10 status", {rsp_valid, rsp_data}, {1'b1, exp_rsp});
      @(negedge clk);
      chk("R11 held", {rsp_valid, rsp_data, in_ready}, {1'b1, exp_rsp, 1'b0});
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R11 released", rsp_valid, 1'b0);
    end
    check_cfg();
  endtask

  task automatic set_col(input int c);
    send(2'd0, 8'h10 | 8'(c >> 4));
    send(2'd0, 8'(c & 15));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] ops2 [5];
    ops2[0] = 8'h81; ops2[1] = 8'hD5; ops2[2] = 8'hD9; ops2[3] = 8'hAD; ops2[4] = 8'hDA;
    for (int i = 0; i < 2048; i++) m_mem[i] = 8'h00;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk("R1 no response", rsp_valid, 1'b0);
    chk("R1 div ratio", div_ratio, 5'd1);
    chk("R1 osc", osc_freq, 4'd5);
    check_cfg();

    // R8 dummy read after address set
    send(2'd0, 8'hB2); set_col(5);
    send(2'd1, 8'hAA); send(2'd1, 8'hBB);
    chk("R6 column advanced", ram_col, 8'd7);
    set_col(5);
    send(2'd2, 8'h00);  // dummy: returns stale latch
    send(2'd2, 8'h00);  // returns AA
    send(2'd2, 8'h00);  // returns BB
    chk("R8 column after reads", ram_col, 8'd8);

    // R7 saturation
    set_col(130);
    send(2'd1, 8'h11); send(2'd1, 8'h22); send(2'd1, 8'h33);
    chk("R7 saturated", ram_col, 8'd131);

    // R9 read-modify-write
    set_col(10);
    send(2'd0, 8'hE0);
    send(2'd2, 8'h00); send(2'd2, 8'h00);
    chk("R9 reads hold column", ram_col, 8'd10);
    send(2'd1, 8'h5A);
    chk("R9 write advances", ram_col, 8'd11);
    send(2'd1, 8'h5B);
    send(2'd0, 8'hEE);
    chk("R9 restored", ram_col, 8'd10);

    // R5 data during parameter wait
    send(2'd0, 8'h81);
    send(2'd1, 8'h55);
    chk("R5 column unchanged", ram_col, 8'd10);
    send(2'd0, 8'h3C);
    chk("R4 contrast param", contrast, 8'h3C);

    // R3 no-op and flags, R10 status with display on
    send(2'd0, 8'hE3);
    send(2'd0, 8'hAF); send(2'd0, 8'hC8); send(2'd0, 8'hA1);
    send(2'd3, 8'h00);
    send(2'd0, 8'hD5); send(2'd0, 8'hAF);
    chk("R4 div from AFh", div_ratio, 5'd16);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int sel;
      sel = int'($urandom % 10);
      case (sel)
        0, 1: send(2'd1, 8'($urandom));
        2, 3: send(2'd2, 8'h00);
        4: send(2'd3, 8'h00);
        5: set_col(int'($urandom % 132));
        6: send(2'd0, 8'hB0 | 8'($urandom % 8));
        7: begin
          send(2'd0, ops2[$urandom % 5]);
          if ($urandom % 2 == 0) send(2'd1, 8'($urandom));
          send(2'd0, 8'($urandom));
        end
        8: send(2'd0, ($urandom % 2 == 0) ? 8'hE0 : 8'hEE);
        default: begin
          logic [7:0] fl [8];
          fl[0] = 8'hA0; fl[1] = 8'hA5; fl[2] = 8'hA6; fl[3] = 8'hA7;
          fl[4] = 8'hAE; fl[5] = 8'hAF; fl[6] = 8'hC0; fl[7] = 8'h40 | 8'($urandom % 64);
          send(2'd0, fl[$urandom % 8] ^ (($urandom % 2 == 0) ? 8'h00 : 8'h01));
        end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule